// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This unit sits beside a small processor core and watches its bus and fetch activity for up to four hardware breakpoints. Every event arrives as an address, a size code and a kind code. Each armed breakpoint compares the event against its own watched byte range and its own selected kind. A match raises a one-cycle debug exception pulse and marks the breakpoint in a sticky status register. The core's single-step logic reports through the same status register and uses the same exception pulse.

Privileged software reaches the unit through a register port with eight indices. Indices 0 to 3 hold the watched addresses, 6 is status and 7 is control. Indices 4 and 5 either act as aliases of 6 and 7 or raise an illegal-access pulse, depending on a debug-extensions input. A guard bit in the control register turns any register access into a faulting trap. The trap suppresses the access, reports itself in status and clears the guard, so the exception handler can then use the registers freely.

Top module: `hw_bkpt_unit`

## Requirements
- R1: Indices 0 to 3 hold the watched address of breakpoints 0 to 3. A read returns the stored value combinationally in the cycle of the request. Synchronous reset clears every register and both pulse outputs.
- R2: Control (index 7) layout is as follows. Breakpoint n is enabled when bit 2n or bit 2n+1 is set. Its kind is bits 16+4n..17+4n and its length is bits 18+4n..19+4n. Bit 13 is the access guard. All other bits read as 0.
- R3: Kind codes are 00 execute, 01 data write, 10 I/O, 11 data read-or-write. Event kind codes are 00 fetch, 01 data write, 10 data read, 11 I/O access. Execute matches fetch, write matches data write, I/O matches I/O access, and read-or-write matches data read or data write.
- R4: Length codes are 00 = 1 byte, 01 = 2, 11 = 4 and 10 = 8. The watched range starts at the watched address with its low bits cleared to the length's alignment. An access of 2^size bytes (size code 0..3) matches when any of its bytes falls inside that range.
- R5: A matching event raises dbg_exc for exactly one cycle, in the cycle after the event. It also sets status bit n for every breakpoint n that matched. Several matches in one event give a single pulse.
- R6: Status bits are sticky and change only on a status write, which loads the written value (bits 0-3, 13, 14). A breakpoint, guard or step event in the same cycle as that write still sets its bit.
- R7: A high step_in sets status bit 14 and raises dbg_exc in the next cycle.
- R8: While the guard bit is set, any register request is blocked: a write has no effect and a read returns 0. The next cycle shows dbg_exc and status bit 13 set, with the guard bit cleared.
- R9: With dbg_ext low, index 4 reads and writes status and index 5 reads and writes control.
- R10: With dbg_ext high, a request to index 4 or 5 is blocked (read returns 0) and raises illegal_exc for one cycle in the next cycle. If the guard bit is set, the guard trap wins and illegal_exc stays low.
- R11: A breakpoint with both enable bits clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Register index 0..7 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle |
| dbg_ext | input | 1 | Debug-extensions mode for indices 4/5 |
| ev_valid | input | 1 | Bus or fetch event present |
| ev_addr | input | 32 | Event start address |
| ev_size | input | 2 | Event size code, 2^code bytes |
| ev_kind | input | 2 | Event kind code |
| step_in | input | 1 | Single-step event from the core |
| dbg_exc | output | 1 | Debug exception pulse |
| illegal_exc | output | 1 | Illegal register access pulse |

## Verification
Breakpoint matching and register access meet in one cycle in two ways, and both are driven on purpose. In the first, a status write coincides with a matching event; the status read back afterwards must keep the new hit bit on top of the written value. In the second, a guarded register access coincides with a matching fetch; a single exception pulse must follow, and status must show both the hit bit and the guard bit. A third case tests the guard trap against the illegal-index path while dbg_ext is high, and only the debug pulse is expected.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    EV_FETCH = 2'b00,
    EV_WRITE = 2'b01,
    EV_READ  = 2'b10,
    EV_IO    = 2'b11
  } ev_kind_e;

  typedef enum logic [1:0] {
    BK_EXEC  = 2'b00,
    BK_WRITE = 2'b01,
    BK_IO    = 2'b10,
    BK_RW    = 2'b11
  } bp_kind_e;

  typedef struct packed {
    logic       en;
    logic [1:0] kind;
    logic [1:0] len;
  } bp_cfg_t;

  localparam int GUARD_BIT    = 13;
  localparam int STEP_BIT     = 14;
  localparam int FIELD_LSB    = 16;
  localparam int FIELD_STRIDE = 4;
  localparam int LEN_OFS      = 2;

  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd1;
      2'b01:   return 4'd2;
      2'b11:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  function automatic logic kind_ok(input logic [1:0] bk, input logic [1:0] ek);
    case (bk)
      BK_EXEC:  return ek == EV_FETCH;
      BK_WRITE: return ek == EV_WRITE;
      BK_IO:    return ek == EV_IO;
      default:  return (ek == EV_READ) || (ek == EV_WRITE);
    endcase
  endfunction

endpackage

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  bp_cfg_t         cfg,
  input  logic [AW-1:0]   watch,
  input  logic            ev_valid,
  input  logic [AW-1:0]   ev_addr,
  input  logic [1:0]      ev_size,
  input  logic [1:0]      ev_kind,
  output logic            hit
);
  localparam logic [AW:0] ONE = (AW+1)'(1);

  logic [3:0]    lb;
  logic [3:0]    sb;
  logic [AW-1:0] lmask;
  logic [AW:0]   wlo, whi, alo, ahi;
  logic          overlap;

  always_comb begin
    lb      = len_bytes(cfg.len);
    sb      = size_bytes(ev_size);
    lmask   = ~({{(AW-4){1'b0}}, lb} - {{(AW-1){1'b0}}, 1'b1});
    wlo     = {1'b0, watch & lmask};
    whi     = wlo + {{(AW-3){1'b0}}, lb} - ONE;
    alo     = {1'b0, ev_addr};
    ahi     = alo + {{(AW-3){1'b0}}, sb} - ONE;
    overlap = (alo <= whi) && (ahi >= wlo);
    hit     = ev_valid && cfg.en && kind_ok(cfg.kind, ev_kind) && overlap;
  end
endmodule

// File: rtl/bkpt_access.sv
module bkpt_access #(
  parameter int IDX_W     = 3,
  parameter int ALIAS_LO  = 4,
  parameter int ALIAS_OFS = 2
) (
  input  logic             req,
  input  logic [IDX_W-1:0] idx,
  input  logic             dbg_ext,
  input  logic             guard_en,
  output logic             gd_trap,
  output logic             illegal_evt,
  output logic             acc_ok,
  output logic [IDX_W-1:0] eff_idx
);
  logic alias_idx;

  always_comb begin
    alias_idx   = (int'(idx) == ALIAS_LO) || (int'(idx) == ALIAS_LO + 1);
    gd_trap     = req && guard_en;
    illegal_evt = req && !guard_en && dbg_ext && alias_idx;
    acc_ok      = req && !guard_en && !(dbg_ext && alias_idx);
    eff_idx     = alias_idx ? idx + IDX_W'(ALIAS_OFS) : idx;
  end
endmodule

// File: rtl/hw_bkpt_unit.sv
module hw_bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int AW     = 32,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_req,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic             dbg_ext,
  input  logic             ev_valid,
  input  logic [AW-1:0]    ev_addr,
  input  logic [1:0]       ev_size,
  input  logic [1:0]       ev_kind,
  input  logic             step_in,
  output logic             dbg_exc,
  output logic             illegal_exc
);
  localparam int BP_IW    = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;
  localparam int STAT_IDX = 6;
  localparam int CTL_IDX  = 7;
  localparam logic [AW-1:0] CTL_MASK =
      AW'((64'd1 << (2 * NUM_BP)) - 64'd1) |
      AW'(64'd1 << GUARD_BIT) |
      AW'(((64'd1 << (FIELD_STRIDE * NUM_BP)) - 64'd1) << FIELD_LSB);
  localparam logic [AW-1:0] STAT_MASK =
      AW'((64'd1 << NUM_BP) - 64'd1) |
      AW'(64'd1 << GUARD_BIT) |
      AW'(64'd1 << STEP_BIT);

  logic [NUM_BP-1:0][AW-1:0] bp_addr_q;
  logic [AW-1:0]             ctl_q, stat_q;
  logic [AW-1:0]             ctl_d, stat_d;
  logic [NUM_BP-1:0]         hit_vec;
  logic                      gd_trap, illegal_evt, acc_ok;
  logic [IDX_W-1:0]          eff_idx;
  logic                      wr_ok, stat_wr, ctl_wr;
  logic                      dbg_exc_q, illegal_q;

  bkpt_access #(
    .IDX_W    (IDX_W),
    .ALIAS_LO (4),
    .ALIAS_OFS(2)
  ) u_access (
    .req        (reg_req),
    .idx        (reg_idx),
    .dbg_ext    (dbg_ext),
    .guard_en   (ctl_q[GUARD_BIT]),
    .gd_trap    (gd_trap),
    .illegal_evt(illegal_evt),
    .acc_ok     (acc_ok),
    .eff_idx    (eff_idx)
  );

  generate
    for (genvar n = 0; n < NUM_BP; n++) begin : g_bp
      bp_cfg_t cfg;
      always_comb begin
        cfg.en   = ctl_q[2*n] | ctl_q[2*n+1];
        cfg.kind = ctl_q[FIELD_LSB + FIELD_STRIDE*n +: 2];
        cfg.len  = ctl_q[FIELD_LSB + FIELD_STRIDE*n + LEN_OFS +: 2];
      end
      bkpt_match #(.AW(AW)) u_match (
        .cfg     (cfg),
        .watch   (bp_addr_q[n]),
        .ev_valid(ev_valid),
        .ev_addr (ev_addr),
        .ev_size (ev_size),
        .ev_kind (ev_kind),
        .hit     (hit_vec[n])
      );
    end
  endgenerate

  always_comb begin
    wr_ok   = acc_ok && reg_we;
    stat_wr = wr_ok && (int'(eff_idx) == STAT_IDX);
    ctl_wr  = wr_ok && (int'(eff_idx) == CTL_IDX);

    ctl_d = ctl_wr ? (reg_wdata & CTL_MASK) : ctl_q;
    if (gd_trap) ctl_d[GUARD_BIT] = 1'b0;

    stat_d = stat_wr ? (reg_wdata & STAT_MASK) : stat_q;
    stat_d[NUM_BP-1:0] = stat_d[NUM_BP-1:0] | hit_vec;
    if (gd_trap) stat_d[GUARD_BIT] = 1'b1;
    if (step_in) stat_d[STEP_BIT]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_addr_q <= '0;
      ctl_q     <= '0;
      stat_q    <= '0;
      dbg_exc_q <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      stat_q    <= stat_d;
      dbg_exc_q <= (|hit_vec) | gd_trap | step_in;
      illegal_q <= illegal_evt;
      if (wr_ok && (int'(eff_idx) < NUM_BP))
        bp_addr_q[eff_idx[BP_IW-1:0]] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (acc_ok && !reg_we) begin
      if (int'(eff_idx) < NUM_BP)          reg_rdata = bp_addr_q[eff_idx[BP_IW-1:0]];
      else if (int'(eff_idx) == STAT_IDX) reg_rdata = stat_q;
      else if (int'(eff_idx) == CTL_IDX)  reg_rdata = ctl_q;
    end
  end

  assign dbg_exc     = dbg_exc_q;
  assign illegal_exc = illegal_q;
endmodule

// File: rtl/bkpt_checker.sv
module bkpt_checker #(
  parameter int NUM_BP = 4,
  parameter int AW     = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 gd_trap,
  input logic                 illegal_evt,
  input logic [NUM_BP-1:0]    hit_vec,
  input logic                 stat_wr,
  input logic                 step_in,
  input logic                 dbg_exc,
  input logic                 illegal_exc,
  input logic [AW-1:0]        stat_q,
  input logic [AW-1:0]        ctl_q,
  input logic [NUM_BP*AW-1:0] bp_addr_flat
);
  AST_GUARD_TRAP: assert property (@(posedge clk) disable iff (rst)
    gd_trap |=> (dbg_exc && stat_q[13] && !ctl_q[13])); // R8

  AST_GUARD_BLOCKS_ADDR: assert property (@(posedge clk) disable iff (rst)
    gd_trap |=> $stable(bp_addr_flat)); // R8

  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    illegal_evt |=> (illegal_exc && !dbg_exc)); // R10

  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    illegal_exc |-> $past(illegal_evt)); // R10

  AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    dbg_exc |-> $past((|hit_vec) || gd_trap || step_in)); // R5

  AST_HIT_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (|hit_vec) |=> (dbg_exc && ((stat_q[NUM_BP-1:0] & $past(hit_vec)) == $past(hit_vec)))); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(stat_wr) |-> ((stat_q & $past(stat_q)) == $past(stat_q))); // R6

  AST_STEP_REPORT: assert property (@(posedge clk) disable iff (rst)
    step_in |=> (dbg_exc && stat_q[14])); // R7
endmodule

bind hw_bkpt_unit bkpt_checker #(.NUM_BP(NUM_BP), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .gd_trap     (gd_trap),
  .illegal_evt (illegal_evt),
  .hit_vec     (hit_vec),
  .stat_wr     (stat_wr),
  .step_in     (step_in),
  .dbg_exc     (dbg_exc),
  .illegal_exc (illegal_exc),
  .stat_q      (stat_q),
  .ctl_q       (ctl_q),
  .bp_addr_flat(bp_addr_q)
);

// File: tb/hw_bkpt_unit_test.sv
module hw_bkpt_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        dbg_ext = 1'b0;
  logic        ev_valid = 1'b0;
  logic [31:0] ev_addr = '0;
  logic [1:0]  ev_size = '0, ev_kind = '0;
  logic        step_in = 1'b0;
  logic        dbg_exc, illegal_exc;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  hw_bkpt_unit uut (
    .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_ext(dbg_ext),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_size(ev_size), .ev_kind(ev_kind),
    .step_in(step_in), .dbg_exc(dbg_exc), .illegal_exc(illegal_exc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input int idx, input logic [31:0] d,
                           output logic exc, output logic ill);
    reg_req = 1'b1; reg_we = 1'b1; reg_idx = 3'(idx); reg_wdata = d;
    step_cycle();
    exc = dbg_exc; ill = illegal_exc;
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input int idx, output logic [31:0] d,
                          output logic exc, output logic ill);
    reg_req = 1'b1; reg_we = 1'b0; reg_idx = 3'(idx);
    #1 d = reg_rdata;
    step_cycle();
    exc = dbg_exc; ill = illegal_exc;
    reg_req = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    logic e, i;
    reg_write(idx, d, e, i);
  endtask

  function automatic logic [31:0] rd_now(input int idx);
    return 32'h0;
  endfunction

  task automatic rd(input int idx, output logic [31:0] d);
    logic e, i;
    reg_read(idx, d, e, i);
  endtask

  task automatic ev_pulse(input logic [31:0] a, input logic [1:0] s, input logic [1:0] k,
                          output logic exc);
    ev_valid = 1'b1; ev_addr = a; ev_size = s; ev_kind = k;
    step_cycle();
    exc = dbg_exc;
    ev_valid = 1'b0;
  endtask

  // bench-side encodings from R2/R3/R4
  function automatic logic [31:0] bp_ctl(input int n, input int en_bit,
                                         input logic [1:0] kind, input logic [1:0] len);
    logic [31:0] v;
    v = 32'h0;
    v[2*n + en_bit] = 1'b1;
    v[16 + 4*n +: 2] = kind;
    v[18 + 4*n +: 2] = len;
    return v;
  endfunction

  function automatic logic model_kind(input logic [1:0] bk, input logic [1:0] ek);
    if (bk == 2'b00) return ek == 2'b00;
    if (bk == 2'b01) return ek == 2'b01;
    if (bk == 2'b10) return ek == 2'b11;
    return (ek == 2'b01) || (ek == 2'b10);
  endfunction

  function automatic logic model_range(input logic [31:0] w, input logic [1:0] lc,
                                       input logic [31:0] a, input logic [1:0] sc);
    longint L, S, base, b;
    L = (lc == 2'b00) ? 1 : (lc == 2'b01) ? 2 : (lc == 2'b11) ? 4 : 8;
    S = 1;
    for (int j = 0; j < sc; j++) S = S * 2;
    base = longint'(w) - (longint'(w) % L);
    for (longint i = 0; i < S; i++) begin
      b = longint'(a) + i;
      if (b >= base && b < base + L) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic t_reset();
    logic [31:0] d; logic e, i;
    chk("R1 reset dbg_exc", 32'(dbg_exc), 32'h0);
    chk("R1 reset illegal_exc", 32'(illegal_exc), 32'h0);
    for (int k = 0; k < 8; k++) begin
      reg_read(k, d, e, i);
      chk($sformatf("R1 reset idx%0d", k), d, 32'h0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) wr(k, 32'hA5000000 + 32'(k * 32'h111));
    for (int k = 0; k < 4; k++) begin
      rd(k, d);
      chk($sformatf("R1 addr idx%0d", k), d, 32'hA5000000 + 32'(k * 32'h111));
    end
    wr(7, 32'hFFFFDFFF);
    rd(7, d);
    chk("R2 control defined bits", d, 32'hFFFF00FF);
    wr(7, 32'h0);
  endtask

  task automatic t_kinds();
    logic e; logic [31:0] d;
    wr(0, 32'h1000);
    for (int bk = 0; bk < 4; bk++) begin
      wr(7, bp_ctl(0, bk % 2, 2'(bk), 2'b00));
      for (int ek = 0; ek < 4; ek++) begin
        wr(6, 32'h0);
        ev_pulse(32'h1000, 2'b00, 2'(ek), e);
        chk($sformatf("R3 kind%0d ev%0d exc", bk, ek), 32'(e), 32'(model_kind(2'(bk), 2'(ek))));
        rd(6, d);
        chk($sformatf("R5 kind%0d ev%0d status", bk, ek), d, 32'(model_kind(2'(bk), 2'(ek))));
      end
    end
  endtask

  task automatic t_lengths();
    logic e;
    wr(1, 32'h2005);
    for (int lc = 0; lc < 4; lc++) begin
      wr(7, bp_ctl(1, 0, 2'b11, 2'(lc)));
      for (int sc = 0; sc < 4; sc++)
        for (int a = 32'h1FFC; a < 32'h2010; a++) begin
          ev_pulse(32'(a), 2'(sc), 2'b10, e);
          chk($sformatf("R4 len%0d size%0d addr %h", lc, sc, a), 32'(e),
              32'(model_range(32'h2005, 2'(lc), 32'(a), 2'(sc))));
        end
    end
  endtask

  task automatic t_disabled();
    logic e; logic [31:0] d, c;
    wr(6, 32'h0);
    wr(2, 32'h5000);
    c = bp_ctl(2, 0, 2'b00, 2'b00);
    c[4] = 1'b0;
    wr(7, c);
    ev_pulse(32'h5000, 2'b00, 2'b00, e);
    chk("R11 disabled no exc", 32'(e), 32'h0);
    rd(6, d);
    chk("R11 disabled no status", d, 32'h0);
    wr(7, bp_ctl(2, 1, 2'b00, 2'b00));
    ev_pulse(32'h5000, 2'b00, 2'b00, e);
    chk("R2 enable via odd bit exc", 32'(e), 32'h1);
    rd(6, d);
    chk("R2 enable via odd bit status", d, 32'h4);
  endtask

  task automatic t_multi();
    logic e; logic [31:0] d;
    wr(6, 32'h0);
    wr(0, 32'h4000); wr(1, 32'h4001);
    wr(7, bp_ctl(0, 0, 2'b11, 2'b11) | bp_ctl(1, 1, 2'b11, 2'b11));
    ev_pulse(32'h4002, 2'b01, 2'b01, e);
    chk("R5 double hit exc", 32'(e), 32'h1);
    step_cycle();
    chk("R5 pulse one cycle", 32'(dbg_exc), 32'h0);
    rd(6, d);
    chk("R5 double hit status", d, 32'h3);
  endtask

  task automatic t_sticky();
    logic e; logic [31:0] d;
    wr(0, 32'h6000);
    wr(7, bp_ctl(0, 0, 2'b00, 2'b00));
    wr(6, 32'h0);
    ev_pulse(32'h6000, 2'b00, 2'b00, e);
    repeat (3) step_cycle();
    rd(6, d);
    chk("R6 sticky after idle", d, 32'h1);
    wr(6, 32'hFFFFFFFF);
    rd(6, d);
    chk("R6 status write mask", d, 32'h600F);
    wr(6, 32'h0);
    rd(6, d);
    chk("R6 status cleared", d, 32'h0);
    reg_req = 1'b1; reg_we = 1'b1; reg_idx = 3'd6; reg_wdata = 32'h0;
    ev_valid = 1'b1; ev_addr = 32'h6000; ev_size = 2'b00; ev_kind = 2'b00;
    step_cycle();
    chk("R6 concurrent exc", 32'(dbg_exc), 32'h1);
    reg_req = 1'b0; reg_we = 1'b0; ev_valid = 1'b0;
    rd(6, d);
    chk("R6 hit survives same-cycle write", d, 32'h1);
  endtask

  task automatic t_step();
    logic [31:0] d;
    wr(7, 32'h0);
    wr(6, 32'h0);
    step_in = 1'b1;
    step_cycle();
    step_in = 1'b0;
    chk("R7 step exc", 32'(dbg_exc), 32'h1);
    rd(6, d);
    chk("R7 step status", d, 32'h4000);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    dbg_ext = 1'b0;
    wr(5, 32'h00230001);
    rd(7, d);
    chk("R9 idx5 writes control", d, 32'h00230001);
    wr(4, 32'h0000000A);
    rd(6, d);
    chk("R9 idx4 writes status", d, 32'h0000000A);
    rd(5, d);
    chk("R9 idx5 reads control", d, 32'h00230001);
  endtask

  task automatic t_illegal();
    logic e, i; logic [31:0] d;
    dbg_ext = 1'b1;
    reg_write(5, 32'h00000004, e, i);
    chk("R10 illegal pulse on write", 32'(i), 32'h1);
    chk("R10 no dbg_exc on illegal", 32'(e), 32'h0);
    step_cycle();
    chk("R10 illegal pulse one cycle", 32'(illegal_exc), 32'h0);
    reg_read(4, d, e, i);
    chk("R10 illegal read data", d, 32'h0);
    chk("R10 illegal pulse on read", 32'(i), 32'h1);
    dbg_ext = 1'b0;
    rd(7, d);
    chk("R10 control untouched", d, 32'h00230001);
  endtask

  task automatic t_guard();
    logic e, i; logic [31:0] d;
    wr(6, 32'h0);
    wr(0, 32'h3000);
    wr(7, bp_ctl(0, 0, 2'b00, 2'b00) | 32'h2000);
    reg_write(0, 32'hDEAD, e, i);
    chk("R8 guard write exc", 32'(e), 32'h1);
    chk("R8 guard write no illegal", 32'(i), 32'h0);
    rd(7, d);
    chk("R8 guard self-clears", d, bp_ctl(0, 0, 2'b00, 2'b00));
    rd(6, d);
    chk("R8 guard status bit", d, 32'h2000);
    rd(0, d);
    chk("R8 blocked write", d, 32'h3000);
    wr(7, 32'h2000);
    reg_read(0, d, e, i);
    chk("R8 guarded read data", d, 32'h0);
    chk("R8 guarded read exc", 32'(e), 32'h1);
    wr(7, 32'h2000);
    dbg_ext = 1'b1;
    reg_read(4, d, e, i);
    chk("R10 guard beats illegal exc", 32'(e), 32'h1);
    chk("R10 guard beats illegal ill", 32'(i), 32'h0);
    dbg_ext = 1'b0;
    wr(6, 32'h0);
    wr(7, bp_ctl(0, 0, 2'b00, 2'b00) | 32'h2000);
    reg_req = 1'b1; reg_we = 1'b1; reg_idx = 3'd6; reg_wdata = 32'h0;
    ev_valid = 1'b1; ev_addr = 32'h3000; ev_size = 2'b00; ev_kind = 2'b00;
    step_cycle();
    chk("R8 guard plus hit exc", 32'(dbg_exc), 32'h1);
    reg_req = 1'b0; reg_we = 1'b0; ev_valid = 1'b0;
    step_cycle();
    chk("R5 guard plus hit single pulse", 32'(dbg_exc), 32'h0);
    rd(6, d);
    chk("R8 guard plus hit status", d, 32'h2001);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_kinds();
    t_lengths();
    t_disabled();
    t_multi();
    t_sticky();
    t_step();
    t_alias();
    t_illegal();
    t_guard();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule